// File: doc/BRIEF.md
# ADC Conversion Sequencer with Tailgating

This block decides when an analog-to-digital converter core runs and for which mode. The core is modelled as a handshake: the sequencer pulses `core_start` with a channel number, and the core later pulses `core_done` with a 12-bit raw sample. Two modes share the core. The single mode converts one selected channel. The scan mode walks an enabled-channel bitmask, one conversion per set bit.

Each mode is started by a one-cycle software command or by a one-cycle pulse on a trigger input that a per-mode select field picks. A per-mode enable gates the hardware trigger. Each mode keeps a pending flag, and an active flag that is high while the mode is pending or converting. Conversions are launched only on the enable pulse of an internal conversion-clock prescaler. An accepted start while the core is idle realigns that prescaler, so the delay from trigger to launch is fixed.

With tailgating on, a pending scan always wins the core. A single request therefore waits until the scan sequence has finished and then runs right after it. Results land in one buffer per mode, each with a data-valid flag.

Top module: `adc_seq_top`

## Requirements
- R1: A start pulse (`sw_*_start`) for a mode that is not active makes that mode active in the next cycle. A stop pulse (`sw_*_stop`) makes the mode inactive in the next cycle. When start and stop for the same mode come in the same cycle, start wins and stop is ignored.
- R2: A hardware start for a mode is `trig_in[sel]` high for one cycle, with `sel` the mode's select field, and it is accepted only while the mode's trigger enable is 1. Pulses on other trigger inputs, or pulses while the enable is 0, have no effect. A software start works whether the enable is 0 or 1.
- R3: When `tailgate_en` is 1, a launch goes to the scan mode whenever scan is pending. When it is 0, a pending single request is launched ahead of the remaining scan channels.
- R4: A scan start captures `scan_mask` and launches channels in ascending index order, one conversion per set bit and one conversion at a time. The scan pending flag drops when the last channel launches. A scan start with an all-zero mask is ignored.
- R5: A start, from software or hardware, for a mode that is already active is absorbed. It adds no extra conversion.
- R6: `single_act` and `scan_act` are high exactly while that mode is pending or its conversion is in progress. Both are low after reset.
- R7: A stop for a mode whose conversion is in progress ends it at once. In the next cycle that mode's result is 0 and its valid flag is 0, and a `core_done` that arrives in the same cycle as the stop is dropped.
- R8: `conv_tick` pulses once every `psc_div`+1 cycles. `core_start` is asserted only in a cycle where `conv_tick` is 1 and the core is idle.
- R9: Any start request, accepted or absorbed, that arrives while no conversion is in progress restarts the prescaler count. The next `conv_tick` comes exactly `psc_div`+1 cycles later.
- R10: With `diff_mode` 1, the 12-bit result is sign-extended from bit 11 to 32 bits as two's complement. With `diff_mode` 0 it is zero-extended, so results range from 0x000 to 0xFFF.
- R11: A mode's valid flag is set in the cycle after its result is written. It is cleared after a read pulse (`*_rd`) or an abort. If a write and a read come in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tailgate_en | input | 1 | Scan has priority over single |
| psc_div | input | PSC_W | Prescaler divide value N (period N+1) |
| diff_mode | input | 1 | Sign-extend results when 1 |
| sw_single_start | input | 1 | Software start, single mode |
| sw_single_stop | input | 1 | Software stop, single mode |
| sw_scan_start | input | 1 | Software start, scan mode |
| sw_scan_stop | input | 1 | Software stop, scan mode |
| trig_in | input | NUM_TRIG | One-cycle hardware trigger pulses |
| single_trig_en | input | 1 | Hardware trigger enable, single mode |
| single_trig_sel | input | clog2(NUM_TRIG) | Trigger input select, single mode |
| scan_trig_en | input | 1 | Hardware trigger enable, scan mode |
| scan_trig_sel | input | clog2(NUM_TRIG) | Trigger input select, scan mode |
| single_ch | input | clog2(NUM_CH) | Channel converted by single mode |
| scan_mask | input | NUM_CH | Enabled channels for scan mode |
| conv_tick | output | 1 | Prescaled conversion-clock enable |
| core_start | output | 1 | Launch pulse to the converter core |
| core_ch | output | clog2(NUM_CH) | Channel for the launched conversion |
| core_done | input | 1 | Core completion pulse |
| core_data | input | RAW_W | Raw core sample |
| single_act | output | 1 | Single mode pending or converting |
| scan_act | output | 1 | Scan mode pending or converting |
| single_rd | input | 1 | Read pulse, single buffer |
| single_result | output | RES_W | Single-mode result |
| single_valid | output | 1 | Single result valid |
| scan_rd | input | 1 | Read pulse, scan buffer |
| scan_result | output | RES_W | Scan-mode result |
| scan_valid | output | 1 | Scan result valid |

## Verification
The arbitration is exercised by a scan and a single request that overlap, once with tailgating on and once with it off. The two runs give different launch orders, which separates the two priority rules. The scan mask `0xA5` has gaps and a top bit, so an order bug or a skipped channel shows up. Starts issued at different prescaler phases and with several divide values distinguish true phase realignment from merely waiting for the next tick. Collisions are driven on purpose: start with stop in the same cycle, a stop during conversion, repeated starts, and reads held through a write. Hardware pulses on the selected input, on an unselected input, and with the enable cleared separate the gating rules. Raw samples with bit 11 set, in both result formats, separate sign extension from zero extension.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RAW_W = 12;
    localparam int RES_W = 32;
    localparam int NMODE = 2;
    localparam int SGL   = 0;
    localparam int SCN   = 1;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_SCAN   = 1'b1
    } mode_e;

    typedef struct packed {
        logic  busy;
        mode_e mode;
    } conv_t;

    typedef struct packed {
        logic             valid;
        logic [RES_W-1:0] data;
    } resbuf_t;

    function automatic logic [RES_W-1:0] fmt_result(input logic [RAW_W-1:0] raw,
                                                    input logic diff);
        fmt_result = {{(RES_W-RAW_W){diff & raw[RAW_W-1]}}, raw};
    endfunction

endpackage

// File: rtl/adc_seq_prescaler.sv
module adc_seq_prescaler #(
    parameter int PSC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PSC_W-1:0] div,
    input  logic             realign,
    output logic             tick
);
    logic [PSC_W-1:0] cnt_q;

    assign tick = (cnt_q >= div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (realign || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_seq_trigsel.sv
module adc_seq_trigsel #(
    parameter int NUM_TRIG = 8,
    parameter int TS_W     = 3
) (
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [TS_W-1:0]     sel,
    input  logic                en,
    input  logic                sw_start,
    input  logic                sw_stop,
    output logic                start_req,
    output logic                stop_eff
);
    logic hw_hit;

    assign hw_hit    = en & trig_in[sel];
    assign start_req = sw_start | hw_hit;
    assign stop_eff  = sw_stop & ~start_req;
endmodule

// File: rtl/adc_seq_resbuf.sv
module adc_seq_resbuf
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr,
    input  logic             rd,
    input  logic             diff,
    input  logic [RAW_W-1:0] raw,
    output logic [RES_W-1:0] result,
    output logic             valid
);
    resbuf_t buf_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            buf_q <= '0;
        end else if (wr) begin
            buf_q.valid <= 1'b1;
            buf_q.data  <= fmt_result(raw, diff);
        end else if (rd) begin
            buf_q.valid <= 1'b0;
        end
    end

    assign result = buf_q.data;
    assign valid  = buf_q.valid;
endmodule

// File: rtl/adc_seq_sched.sv
module adc_seq_sched
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tailgate_en,
    input  logic              tick,
    input  logic [NMODE-1:0]  start_req,
    input  logic [NMODE-1:0]  stop_eff,
    input  logic [CH_W-1:0]   single_ch,
    input  logic [NUM_CH-1:0] scan_mask,
    input  logic              core_done,
    output logic              core_start,
    output logic [CH_W-1:0]   core_ch,
    output logic [NMODE-1:0]  act,
    output logic [NMODE-1:0]  wr,
    output logic [NMODE-1:0]  clr,
    output logic              busy,
    output mode_e             cur_mode
);
    logic [NMODE-1:0]  pend_q;
    logic [NUM_CH-1:0] rem_q;
    logic [NUM_CH-1:0] rem_next;
    conv_t             conv_q;
    logic [NMODE-1:0]  elig;
    mode_e             pick;
    logic              launch;
    logic              abort;

    function automatic logic [CH_W-1:0] low_idx(input logic [NUM_CH-1:0] v);
        low_idx = '0;
        for (int i = NUM_CH-1; i >= 0; i--) begin
            if (v[i]) low_idx = CH_W'(i);
        end
    endfunction

    assign elig     = pend_q & ~stop_eff;
    assign rem_next = rem_q & (rem_q - 1'b1);

    always_comb begin
        if (tailgate_en && elig[SCN])  pick = MODE_SCAN;
        else if (elig[SGL])            pick = MODE_SINGLE;
        else                           pick = MODE_SCAN;
    end

    assign launch     = ~conv_q.busy & tick & (|elig);
    assign core_start = launch;
    assign core_ch    = (pick == MODE_SCAN) ? low_idx(rem_q) : single_ch;
    assign abort      = conv_q.busy & stop_eff[conv_q.mode];
    assign busy       = conv_q.busy;
    assign cur_mode   = conv_q.mode;

    for (genvar m = 0; m < NMODE; m++) begin : g_mode
        logic own;
        assign own    = conv_q.busy & (conv_q.mode == mode_e'(m));
        assign act[m] = pend_q[m] | own;
        assign wr[m]  = own & core_done & ~abort;
        assign clr[m] = own & abort;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            rem_q  <= '0;
            conv_q <= '0;
        end else begin
            if (start_req[SGL] && !act[SGL]) begin
                pend_q[SGL] <= 1'b1;
            end else if (stop_eff[SGL]) begin
                pend_q[SGL] <= 1'b0;
            end else if (launch && pick == MODE_SINGLE) begin
                pend_q[SGL] <= 1'b0;
            end

            if (start_req[SCN] && !act[SCN] && (|scan_mask)) begin
                pend_q[SCN] <= 1'b1;
                rem_q       <= scan_mask;
            end else if (stop_eff[SCN]) begin
                pend_q[SCN] <= 1'b0;
                rem_q       <= '0;
            end else if (launch && pick == MODE_SCAN) begin
                pend_q[SCN] <= |rem_next;
                rem_q       <= rem_next;
            end

            if (launch) begin
                conv_q.busy <= 1'b1;
                conv_q.mode <= pick;
            end else if (abort || (conv_q.busy && core_done)) begin
                conv_q.busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NUM_TRIG = 8,
    parameter int PSC_W    = 4,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int TS_W    = $clog2(NUM_TRIG)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tailgate_en,
    input  logic [PSC_W-1:0]    psc_div,
    input  logic                diff_mode,
    input  logic                sw_single_start,
    input  logic                sw_single_stop,
    input  logic                sw_scan_start,
    input  logic                sw_scan_stop,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic                single_trig_en,
    input  logic [TS_W-1:0]     single_trig_sel,
    input  logic                scan_trig_en,
    input  logic [TS_W-1:0]     scan_trig_sel,
    input  logic [CH_W-1:0]     single_ch,
    input  logic [NUM_CH-1:0]   scan_mask,
    output logic                conv_tick,
    output logic                core_start,
    output logic [CH_W-1:0]     core_ch,
    input  logic                core_done,
    input  logic [RAW_W-1:0]    core_data,
    output logic                single_act,
    output logic                scan_act,
    input  logic                single_rd,
    output logic [RES_W-1:0]    single_result,
    output logic                single_valid,
    input  logic                scan_rd,
    output logic [RES_W-1:0]    scan_result,
    output logic                scan_valid
);
    logic [NMODE-1:0]            sw_start_v, sw_stop_v, trig_en_v, rd_v;
    logic [NMODE-1:0][TS_W-1:0]  trig_sel_v;
    logic [NMODE-1:0]            start_req, stop_eff, act_v, wr_v, clr_v, valid_v;
    logic [NMODE-1:0][RES_W-1:0] res_v;
    logic                        conv_busy;
    mode_e                       cur_mode;
    logic                        realign;

    assign sw_start_v = {sw_scan_start,  sw_single_start};
    assign sw_stop_v  = {sw_scan_stop,   sw_single_stop};
    assign trig_en_v  = {scan_trig_en,   single_trig_en};
    assign trig_sel_v = {scan_trig_sel,  single_trig_sel};
    assign rd_v       = {scan_rd,        single_rd};

    for (genvar m = 0; m < NMODE; m++) begin : g_mode
        adc_seq_trigsel #(.NUM_TRIG(NUM_TRIG), .TS_W(TS_W)) u_trig (
            .trig_in  (trig_in),
            .sel      (trig_sel_v[m]),
            .en       (trig_en_v[m]),
            .sw_start (sw_start_v[m]),
            .sw_stop  (sw_stop_v[m]),
            .start_req(start_req[m]),
            .stop_eff (stop_eff[m])
        );

        adc_seq_resbuf u_buf (
            .clk   (clk),
            .rst   (rst),
            .clr   (clr_v[m]),
            .wr    (wr_v[m]),
            .rd    (rd_v[m]),
            .diff  (diff_mode),
            .raw   (core_data),
            .result(res_v[m]),
            .valid (valid_v[m])
        );
    end

    assign realign = (|start_req) & ~conv_busy;

    adc_seq_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst    (rst),
        .div    (psc_div),
        .realign(realign),
        .tick   (conv_tick)
    );

    adc_seq_sched #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sched (
        .clk        (clk),
        .rst        (rst),
        .tailgate_en(tailgate_en),
        .tick       (conv_tick),
        .start_req  (start_req),
        .stop_eff   (stop_eff),
        .single_ch  (single_ch),
        .scan_mask  (scan_mask),
        .core_done  (core_done),
        .core_start (core_start),
        .core_ch    (core_ch),
        .act        (act_v),
        .wr         (wr_v),
        .clr        (clr_v),
        .busy       (conv_busy),
        .cur_mode   (cur_mode)
    );

    assign single_act    = act_v[SGL];
    assign scan_act      = act_v[SCN];
    assign single_result = res_v[SGL];
    assign single_valid  = valid_v[SGL];
    assign scan_result   = res_v[SCN];
    assign scan_valid    = valid_v[SCN];
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker
    import adc_seq_pkg::*;
#(
    parameter int PSC_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tailgate_en,
    input logic [PSC_W-1:0] psc_div,
    input logic             conv_tick,
    input logic             core_start,
    input logic             core_done,
    input logic             single_act,
    input logic             scan_act,
    input logic             single_valid,
    input logic [RES_W-1:0] single_result,
    input logic [NMODE-1:0] start_req,
    input logic [NMODE-1:0] stop_eff,
    input logic             conv_busy,
    input mode_e            cur_mode
);
    AST_START_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        core_start |-> conv_tick); // R8

    AST_LAUNCH_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        core_start |=> (single_act || scan_act)); // R6

    AST_START_ACTIVATES: assert property (@(posedge clk) disable iff (rst)
        (start_req[SGL] && !single_act) |=> single_act); // R1

    AST_STOP_DEACTIVATES: assert property (@(posedge clk) disable iff (rst)
        stop_eff[SGL] |=> !single_act); // R1

    AST_ABORT_CLEARS_BUF: assert property (@(posedge clk) disable iff (rst)
        (stop_eff[SGL] && conv_busy && cur_mode == MODE_SINGLE)
        |=> (!single_valid && single_result == '0)); // R7

    AST_TAILGATE_SCAN_FIRST: assert property (@(posedge clk) disable iff (rst)
        (tailgate_en && core_start && scan_act && !stop_eff[SCN])
        |=> (cur_mode == MODE_SCAN)); // R3

    AST_VALID_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (core_done && conv_busy && cur_mode == MODE_SINGLE && !stop_eff[SGL])
        |=> single_valid); // R11

    AST_REALIGN_PHASE: assert property (@(posedge clk) disable iff (rst)
        ((|start_req) && !conv_busy) |=> (conv_tick == (psc_div == '0))); // R9
endmodule

bind adc_seq_top adc_seq_checker #(.PSC_W(PSC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tailgate_en  (tailgate_en),
    .psc_div      (psc_div),
    .conv_tick    (conv_tick),
    .core_start   (core_start),
    .core_done    (core_done),
    .single_act   (single_act),
    .scan_act     (scan_act),
    .single_valid (single_valid),
    .single_result(single_result),
    .start_req    (start_req),
    .stop_eff     (stop_eff),
    .conv_busy    (conv_busy),
    .cur_mode     (cur_mode)
);

// File: tb/adc_seq_top_bench.sv
`timescale 1ns/1ps
module adc_seq_top_bench;
    localparam int NUM_CH   = 8;
    localparam int NUM_TRIG = 8;
    localparam int PSC_W    = 4;
    localparam int LAT      = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tailgate_en = 1'b1;
    logic [3:0]  psc_div = '0;
    logic        diff_mode = 1'b0;
    logic        sw_single_start = 1'b0, sw_single_stop = 1'b0;
    logic        sw_scan_start = 1'b0, sw_scan_stop = 1'b0;
    logic [7:0]  trig_in = '0;
    logic        single_trig_en = 1'b0, scan_trig_en = 1'b0;
    logic [2:0]  single_trig_sel = '0, scan_trig_sel = '0;
    logic [2:0]  single_ch = 3'd2;
    logic [7:0]  scan_mask = '0;
    logic        conv_tick, core_start;
    logic [2:0]  core_ch;
    logic        core_done = 1'b0;
    logic [11:0] core_data = '0;
    logic        single_act, scan_act;
    logic        single_rd = 1'b0, scan_rd = 1'b0;
    logic [31:0] single_result, scan_result;
    logic        single_valid, scan_valid;

    always #2.5 clk = ~clk;

    adc_seq_top #(.NUM_CH(NUM_CH), .NUM_TRIG(NUM_TRIG), .PSC_W(PSC_W)) u_adc_seq_top (
        .clk(clk), .rst(rst), .tailgate_en(tailgate_en), .psc_div(psc_div),
        .diff_mode(diff_mode), .sw_single_start(sw_single_start),
        .sw_single_stop(sw_single_stop), .sw_scan_start(sw_scan_start),
        .sw_scan_stop(sw_scan_stop), .trig_in(trig_in),
        .single_trig_en(single_trig_en), .single_trig_sel(single_trig_sel),
        .scan_trig_en(scan_trig_en), .scan_trig_sel(scan_trig_sel),
        .single_ch(single_ch), .scan_mask(scan_mask), .conv_tick(conv_tick),
        .core_start(core_start), .core_ch(core_ch), .core_done(core_done),
        .core_data(core_data), .single_act(single_act), .scan_act(scan_act),
        .single_rd(single_rd), .single_result(single_result),
        .single_valid(single_valid), .scan_rd(scan_rd),
        .scan_result(scan_result), .scan_valid(scan_valid)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R6";

    // reference model state
    int          m_cnt = 0;
    bit          m_spend = 0;
    int          scanq[$];
    bit          m_busy = 0;
    int          m_mode = 0;
    longint      m_res[2] = '{0, 0};
    bit          m_val[2] = '{0, 0};
    int          core_cd = 0;
    int          seq = 0;
    logic [11:0] core_val = '0;

    task automatic chk(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic model_cycle();
        bit ss, cs, sp, cp, tick, acts, actc, es, ec, lau, abort, pend_s;
        int pk, ech;
        longint fmt;
        ss   = sw_single_start | (single_trig_en & trig_in[single_trig_sel]);
        cs   = sw_scan_start   | (scan_trig_en   & trig_in[scan_trig_sel]);
        sp   = sw_single_stop & !ss;
        cp   = sw_scan_stop   & !cs;
        tick = (m_cnt >= int'(psc_div));
        pend_s = (scanq.size() != 0);
        acts = m_spend | (m_busy && m_mode == 0);
        actc = pend_s  | (m_busy && m_mode == 1);
        es   = m_spend & !sp;
        ec   = pend_s & !cp;
        lau  = !m_busy & tick & (es | ec);
        pk   = (tailgate_en && ec) ? 1 : (es ? 0 : 1);
        ech  = (pk == 1) ? ((scanq.size() != 0) ? scanq[0] : 0) : int'(single_ch);

        chk("conv_tick (R8)",   longint'(conv_tick),  longint'(tick));
        chk("core_start (R3)",  longint'(core_start), longint'(lau));
        if (lau) chk("core_ch (R4)", longint'(core_ch), longint'(ech));
        chk("single_act (R6)",  longint'(single_act), longint'(acts));
        chk("scan_act (R6)",    longint'(scan_act),   longint'(actc));
        chk("single_result (R10)", longint'(single_result), m_res[0]);
        chk("single_valid (R11)",  longint'(single_valid),  longint'(m_val[0]));
        chk("scan_result (R10)",   longint'(scan_result),   m_res[1]);
        chk("scan_valid (R11)",    longint'(scan_valid),    longint'(m_val[1]));

        abort = m_busy & ((m_mode == 0 && sp) || (m_mode == 1 && cp));
        fmt = longint'(core_data);
        if (diff_mode && core_data[11]) fmt = fmt | 64'hFFFF_F000;
        for (int m = 0; m < 2; m++) begin
            bit rdm = (m == 0) ? single_rd : scan_rd;
            if (abort && m_mode == m) begin
                m_res[m] = 0; m_val[m] = 0;
            end else if (m_busy && core_done && m_mode == m) begin
                m_res[m] = fmt; m_val[m] = 1;
            end else if (rdm) begin
                m_val[m] = 0;
            end
        end

        if (ss && !acts)            m_spend = 1;
        else if (sp)                m_spend = 0;
        else if (lau && pk == 0)    m_spend = 0;

        if (cs && !actc && scan_mask != 0) begin
            scanq.delete();
            for (int i = 0; i < NUM_CH; i++) if (scan_mask[i]) scanq.push_back(i);
        end else if (cp) begin
            scanq.delete();
        end else if (lau && pk == 1) begin
            void'(scanq.pop_front());
        end

        if ((ss || cs) && !m_busy) m_cnt = 0;
        else if (tick)             m_cnt = 0;
        else                       m_cnt++;

        if (lau) begin
            m_busy = 1; m_mode = pk;
        end else if (abort || (m_busy && core_done)) begin
            m_busy = 0;
        end

        if (core_cd > 0) core_cd--;
        if (lau) begin
            core_cd  = LAT;
            core_val = 12'((seq * 2471 + 2109) & 12'hFFF);
            seq++;
        end
    endtask

    task automatic step();
        core_done = (core_cd == 1);
        core_data = core_val;
        @(negedge clk);
        model_cycle();
        @(posedge clk);
        #1;
        sw_single_start = 0; sw_single_stop = 0;
        sw_scan_start = 0;   sw_scan_stop = 0;
        trig_in = '0; single_rd = 0; scan_rd = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        cur_req = "R6";  idle(3);

        cur_req = "R8";  psc_div = 3; idle(10);
        sw_single_start = 1; step(); idle(12);

        cur_req = "R9";  idle(2); sw_single_start = 1; step(); idle(11);
        sw_single_start = 1; step(); idle(10);
        psc_div = 5; idle(3); sw_scan_start = 1; scan_mask = 8'h01; step(); idle(20);

        cur_req = "R4";  psc_div = 1; scan_mask = 8'hA5;
        sw_scan_start = 1; step(); idle(30);
        scan_mask = 8'h00; sw_scan_start = 1; step(); idle(5);

        cur_req = "R3";  tailgate_en = 1; scan_mask = 8'h0E;
        sw_scan_start = 1; step(); idle(3); sw_single_start = 1; step(); idle(30);
        tailgate_en = 0;
        sw_scan_start = 1; step(); idle(3); sw_single_start = 1; step(); idle(30);
        tailgate_en = 1;

        cur_req = "R1";  psc_div = 6;
        sw_single_start = 1; sw_single_stop = 1; step(); idle(2);
        sw_single_stop = 1; step(); idle(10);
        sw_scan_start = 1; sw_scan_stop = 1; step(); idle(40);
        sw_scan_start = 1; step(); idle(2); sw_scan_stop = 1; step(); idle(10);

        cur_req = "R7";  psc_div = 0;
        sw_single_start = 1; step(); idle(2); sw_single_stop = 1; step(); idle(8);
        scan_mask = 8'hF0; sw_scan_start = 1; step(); idle(6);
        sw_scan_stop = 1; step(); idle(8);
        sw_single_start = 1; step(); idle(3); sw_single_stop = 1; step(); idle(8);

        cur_req = "R2";  single_trig_en = 1; single_trig_sel = 3'd5; psc_div = 2;
        trig_in = 8'h20; step(); idle(10);
        trig_in = 8'h08; step(); idle(6);
        single_trig_en = 0; trig_in = 8'h20; step(); idle(6);
        single_trig_en = 1; sw_single_start = 1; step(); idle(10);
        scan_trig_en = 1; scan_trig_sel = 3'd2; scan_mask = 8'h81;
        trig_in = 8'h04; step(); idle(20);

        cur_req = "R5";  psc_div = 3;
        sw_single_start = 1; step(); sw_single_start = 1; step(); idle(2);
        trig_in = 8'h20; step(); idle(10);
        scan_mask = 8'h06; sw_scan_start = 1; step(); idle(2);
        sw_scan_start = 1; step(); idle(20);

        cur_req = "R10"; diff_mode = 1; psc_div = 0;
        for (int k = 0; k < 6; k++) begin
            single_ch = 3'(k); sw_single_start = 1; step(); idle(6);
        end
        scan_mask = 8'hFF; sw_scan_start = 1; step(); idle(40);
        diff_mode = 0;
        for (int k = 0; k < 4; k++) begin
            sw_single_start = 1; step(); idle(6);
        end

        cur_req = "R11";
        single_rd = 1; scan_rd = 1; step(); idle(2);
        sw_single_start = 1; step();
        for (int k = 0; k < 10; k++) begin
            single_rd = 1; step();
        end
        sw_scan_start = 1; scan_mask = 8'h03; step();
        for (int k = 0; k < 14; k++) begin
            scan_rd = (k % 2 == 0); step();
        end
        idle(5);

        finish_run();
    end
endmodule